// File: doc/BRIEF.md
# Serial Shift Output Controller

This block drives up to 32 output bits off-chip through an external shift-register chain. It generates a serial clock, a serial data line and a one-cycle store strobe. The 32 bits form four groups of eight, and each group can be switched into or out of the chain. Software writes an output image and a few control fields through a simple write port. A transfer then sends the enabled groups and latches them.

A transfer starts in one of two ways. Software can write a self-clearing update bit. Otherwise a periodic scheduler fires from one of two divided timebases: a fast one, nominally 50 to 250 kHz, and a slow one, nominally 2 to 10 Hz. A trigger that arrives while a transfer is running is held, and it is served once that transfer has finished. The image is captured when a transfer starts, so software may rewrite it at any time.

With the default parameters and a 200 MHz clock, the shift clock runs at 25, 12.5, 6.25 or 3.125 MHz. The timebase units are 200 clocks for the fast source and 5,000,000 clocks for the slow source. Each selectable period is 20, 10, 5 or 4 units.

Top module: `sso_ctrl`

## Requirements
- R1: After reset, sclk_o and sdo_o and latch_o are 0, the output image is all zeros and no group is enabled. A transfer with only group 0 enabled then shifts eight 0 bits.
- R2: Register 1 bits 3:0 enable groups 0..3. Group g holds image bits 8g+7..8g. Only enabled groups are shifted. The highest enabled group goes first, most significant bit first, and the chain continues straight on into the next lower enabled group.
- R3: Register 1 bits 5:4 (code s) set the bit cell to 8<<s clock cycles, one serial-clock period per bit.
- R4: Register 0 bit 26 selects the data edge. With 0, data changes together with a rising sclk_o and the idle level is 0. With 1, data changes together with a falling sclk_o and the idle level is 1. Data is stable at the opposite edge in the middle of each cell.
- R5: Writing register 0 with bit 31 set, while no periodic update is running, starts exactly one transfer. The bit is not stored and clears itself.
- R6: Update triggers that arrive during a transfer merge into one pending request. That request is served as soon as the transfer ends.
- R7: After the last bit, latch_o is high for exactly one cycle while sclk_o sits at its idle level.
- R8: Register 1 bits 7:6 pick the update source: 0 software, 1 fast timebase, 2 slow timebase. Bits 11:10 (fast) or 9:8 (slow) select a period of 20, 10, 5 or 4 units for codes 0..3. While periodic updates run, latch pulses repeat exactly one period apart.
- R9: Periodic updates run only when register 0 bit 30 is set and the source is 1 or 2. While they run, the software update bit is ignored. With bit 30 clear, no periodic transfer occurs and software updates work.
- R10: The image (register 2) is captured at transfer start. A write to it during a transfer affects only the next transfer.
- R11: A trigger accepted while no group is enabled produces no clock edge and no latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 200 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 configuration, 2 image |
| wr_data | input | 32 | Register write data |
| sclk_o | output | 1 | Serial shift clock |
| sdo_o | output | 1 | Serial data |
| latch_o | output | 1 | One-cycle store strobe for the external chain |

## Verification
The hardest case to reach from the ports is a trigger that lands while a transfer is already under way. Serving it depends on the pending request outliving the running transfer and merging with later triggers. The stimulus reaches this case by enabling all four groups at the fastest rate, which gives a 256-cycle transfer. It writes a new image and two further strobes about thirty cycles into that transfer. It then expects exactly two frames, the first carrying the old image and the second the new one. A second difficult case is periodic spacing, where the bench measures the distance between latch pulses against the selected period after the first pulses have settled.

// File: rtl/sso_ctrl.sv
module sso_ctrl #(
  parameter int SLOW_UNIT   = 5_000_000,
  parameter int FAST_UNIT   = 200,
  parameter int SCK_DIV_MIN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        sclk_o,
  output logic        sdo_o,
  output logic        latch_o
);
  localparam int UNIT_MAX = (SLOW_UNIT > FAST_UNIT) ? SLOW_UNIT : FAST_UNIT;
  localparam int PW       = $clog2(20 * UNIT_MAX + 1);
  localparam int PHW      = $clog2(SCK_DIV_MIN * 8);
  localparam int DW       = PHW + 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_SHIFT = 2'd1, S_LATCH = 2'd2;

  logic          per_en, edge_sel;
  logic [3:0]    grp_en;
  logic [1:0]    sck_sel, src, sdiv, fdiv;
  logic [31:0]   image;
  logic [1:0]    st;
  logic          pend;
  logic [31:0]   sh;
  logic [3:0]    gq;
  logic [4:0]    idx;
  logic [PHW-1:0] ph;
  logic [PW-1:0] tc;

  function automatic logic [2:0] grp_below(input logic [3:0] m, input logic [2:0] lim);
    logic [2:0] r;
    r = '0;
    for (int g = 0; g < 4; g++)
      if (m[g] && (g < int'(lim))) r = {1'b1, 2'(g)};
    return r;
  endfunction

  function automatic int mult(input logic [1:0] s);
    case (s)
      2'd0:    return 20;
      2'd1:    return 10;
      2'd2:    return 5;
      default: return 4;
    endcase
  endfunction

  wire per_run = per_en && (src == 2'd1 || src == 2'd2);
  logic [PW-1:0] period;
  assign period = PW'((src == 2'd2 ? SLOW_UNIT : FAST_UNIT) * mult(src == 2'd2 ? sdiv : fdiv));
  wire tick     = per_run && (tc >= period - 1'b1);
  wire sw_go    = wr_en && (wr_addr == 2'd0) && wr_data[31] && !per_run;
  wire start    = (st == S_IDLE) && pend;

  logic [DW-1:0] div;
  assign div = DW'(SCK_DIV_MIN) << sck_sel;
  wire [2:0] top      = grp_below(grp_en, 3'd4);
  wire [2:0] nxt      = grp_below(gq, {1'b0, idx[4:3]});
  wire       cell_end = (ph == PHW'(div - 1'b1));
  wire       hi       = ({1'b0, ph} < (div >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_en <= 1'b0; edge_sel <= 1'b0; grp_en <= '0; sck_sel <= '0;
      src <= '0; sdiv <= '0; fdiv <= '0; image <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin per_en <= wr_data[30]; edge_sel <= wr_data[26]; end
        2'd1: begin
          grp_en <= wr_data[3:0]; sck_sel <= wr_data[5:4]; src <= wr_data[7:6];
          sdiv <= wr_data[9:8]; fdiv <= wr_data[11:10];
        end
        2'd2: image <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !per_run) tc <= '0;
    else if (tick)          tc <= '0;
    else                    tc <= tc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !start) || tick || sw_go;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; gq <= '0; idx <= '0; ph <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && top[2]) begin
          st <= S_SHIFT; sh <= image; gq <= grp_en;
          idx <= {top[1:0], 3'b111}; ph <= '0;
        end
        S_SHIFT: if (cell_end) begin
          ph <= '0;
          if (idx[2:0] != 3'd0) idx <= idx - 1'b1;
          else if (nxt[2])      idx <= {nxt[1:0], 3'b111};
          else                  st  <= S_LATCH;
        end else ph <= ph + 1'b1;
        S_LATCH: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk_o  = (st == S_SHIFT) ? (hi ^ edge_sel) : edge_sel;
  assign sdo_o   = (st == S_SHIFT) && sh[idx];
  assign latch_o = (st == S_LATCH);
endmodule

// File: rtl/sso_ctrl_chk.sv
module sso_ctrl_chk #(parameter int PHW = 6) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk_o,
  input logic           sdo_o,
  input logic           latch_o,
  input logic [1:0]     st,
  input logic           edge_sel,
  input logic           pend,
  input logic           sw_go,
  input logic [PHW-1:0] ph,
  input logic [PHW:0]   div,
  input logic [3:0]     gq,
  input logic [4:0]     idx
);
  a_r7_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o);
  a_r7_latch_idle_clk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> (sclk_o == edge_sel));
  a_r7_latch_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_o) |-> ($past(st) == 2'd1));
  a_r4_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 2'd1) && ($past(st) == 2'd1) && (sdo_o != $past(sdo_o))) |-> (sclk_o != edge_sel));
  a_r5_strobe_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sw_go |=> pend);
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> ({1'b0, ph} < div));
  a_r2_group_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> gq[idx[4:3]]);
endmodule

bind sso_ctrl sso_ctrl_chk #(.PHW(PHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .sdo_o(sdo_o), .latch_o(latch_o),
  .st(st), .edge_sel(edge_sel), .pend(pend), .sw_go(sw_go), .ph(ph), .div(div),
  .gq(gq), .idx(idx)
);

// File: tb/sso_ctrl_tb_top.sv
module sso_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SU = 100;
  localparam int FU = 40;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic sclk_o, sdo_o, latch_o;

  sso_ctrl #(.SLOW_UNIT(SU), .FAST_UNIT(FU), .SCK_DIV_MIN(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .latch_o(latch_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic edge_m = 1'b0, mon_clr = 1'b0;
  int exp_div = 8;
  int cyc = 0, nbits = 0, gap_err = 0, idle_err = 0, wide_err = 0, frames = 0;
  int last_s = 0, lat_last = 0, lat_prev = 0;
  logic [31:0] rx = '0;
  logic [31:0] fr_data [8];
  int fr_bits [8];
  logic prev = 1'b0, prev_latch = 1'b0, samp;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n || mon_clr) begin
      rx = '0; nbits = 0; gap_err = 0; idle_err = 0; wide_err = 0;
      prev = sclk_o; prev_latch = latch_o;
    end else begin
      samp = edge_m ? (!prev && sclk_o) : (prev && !sclk_o);
      if (samp) begin
        if (nbits > 0 && (cyc - last_s) != exp_div) gap_err = gap_err + 1;
        last_s = cyc; rx = {rx[30:0], sdo_o}; nbits = nbits + 1;
      end
      if (latch_o) begin
        if (prev_latch) wide_err = wide_err + 1;
        else begin
          fr_data[frames % 8] = rx; fr_bits[frames % 8] = nbits;
          frames = frames + 1; lat_prev = lat_last; lat_last = cyc;
          if (sclk_o != edge_m) idle_err = idle_err + 1;
          rx = '0; nbits = 0;
        end
      end
      prev = sclk_o; prev_latch = latch_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    repeat (3) @(posedge clk);
    #1 mon_clr = 1'b0;
  endtask

  task automatic wait_frames(input int target, input string req);
    for (int i = 0; i < 20000 && frames < target; i++) @(negedge clk);
    chk(frames >= target, req, 64'(frames), 64'(target));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_data(input logic [3:0] g, input logic [31:0] img);
    logic [31:0] d = '0;
    for (int k = 3; k >= 0; k--) if (g[k]) d = {d[23:0], img[k*8 +: 8]};
    return d;
  endfunction

  function automatic int exp_n(input logic [3:0] g);
    return 8 * $countones(g);
  endfunction

  // {pad, groups, clock select, edge, image}
  localparam logic [39:0] VEC [6] = '{
    {1'b0, 4'b0001, 2'd0, 1'b0, 32'hA5C3_0F96},
    {1'b0, 4'b1111, 2'd0, 1'b0, 32'h1234_5678},
    {1'b0, 4'b1010, 2'd1, 1'b1, 32'hDEAD_BEEF},
    {1'b0, 4'b0110, 2'd2, 1'b0, 32'h8001_7FFE},
    {1'b0, 4'b1000, 2'd3, 1'b1, 32'hF0F0_0F0F},
    {1'b0, 4'b0101, 2'd0, 1'b1, 32'hCAFE_0001}
  };

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_o == 1'b0 && sdo_o == 1'b0 && latch_o == 1'b0, "R1 reset outputs",
        64'({sclk_o, sdo_o, latch_o}), 64'd0);

    // R11: no groups enabled at reset, strobe gives nothing
    wr(0, 32'h8000_0000);
    idle(300);
    chk(frames == 0, "R11 no groups no latch", 64'(frames), 64'd0);
    chk(sclk_o == 1'b0 && nbits == 0, "R11 no clock edge", 64'(nbits), 64'd0);

    // R1: image zero after reset
    wr(1, 32'h0000_0001);
    clear_mon();
    f0 = frames;
    wr(0, 32'h8000_0000);
    wait_frames(f0 + 1, "R1 frame");
    chk(fr_data[f0 % 8] == 32'd0 && fr_bits[f0 % 8] == 8, "R1 zero image",
        64'({fr_data[f0 % 8], 32'(fr_bits[f0 % 8])}), 64'({32'd0, 32'd8}));

    for (int v = 0; v < 6; v++) begin
      logic [3:0] g; logic [1:0] s; logic e; logic [31:0] img;
      {g, s, e, img} = VEC[v][38:0];
      wr(1, {26'd0, s, g});
      wr(0, 32'(e) << 26);
      edge_m = e; exp_div = 8 << s;
      clear_mon();
      wr(2, img);
      f0 = frames;
      wr(0, (32'(e) << 26) | 32'h8000_0000);
      wait_frames(f0 + 1, "R5 frame");
      chk(fr_data[f0 % 8] == exp_data(g, img) && fr_bits[f0 % 8] == exp_n(g), "R2 R4 frame",
          64'({fr_data[f0 % 8], 32'(fr_bits[f0 % 8])}), 64'({exp_data(g, img), 32'(exp_n(g))}));
      chk(gap_err == 0, "R3 cell length", 64'(gap_err), 64'd0);
      chk(idle_err == 0 && wide_err == 0, "R7 latch", 64'({idle_err, wide_err}), 64'd0);
      idle(600);
      chk(frames == f0 + 1, "R5 exactly one", 64'(frames), 64'(f0 + 1));
    end

    // R6 and R10: strobes during a transfer, image rewritten mid-transfer
    wr(1, 32'h0000_000F);
    wr(0, 32'h0);
    edge_m = 1'b0; exp_div = 8;
    clear_mon();
    wr(2, 32'h0BAD_F00D);
    f0 = frames;
    wr(0, 32'h8000_0000);
    idle(30);
    wr(2, 32'h7E57_C0DE);
    wr(0, 32'h8000_0000);
    wr(0, 32'h8000_0000);
    wait_frames(f0 + 2, "R6 frames");
    idle(600);
    chk(frames == f0 + 2, "R6 merged pending", 64'(frames), 64'(f0 + 2));
    chk(fr_data[f0 % 8] == 32'h0BAD_F00D, "R10 snapshot", 64'(fr_data[f0 % 8]), 64'h0BAD_F00D);
    chk(fr_data[(f0 + 1) % 8] == 32'h7E57_C0DE, "R10 next image",
        64'(fr_data[(f0 + 1) % 8]), 64'h7E57_C0DE);

    // R8: periodic spacing
    wr(1, {20'd0, 2'd3, 2'd0, 2'd1, 2'd0, 4'b0001});
    wr(0, 32'h4000_0000);
    f0 = frames;
    wait_frames(f0 + 3, "R8 fast run");
    chk(lat_last - lat_prev == FU * 4, "R8 fast code 3", 64'(lat_last - lat_prev), 64'(FU * 4));
    wr(1, {20'd0, 2'd0, 2'd0, 2'd1, 2'd0, 4'b0001});
    f0 = frames;
    wait_frames(f0 + 3, "R8 fast run 0");
    chk(lat_last - lat_prev == FU * 20, "R8 fast code 0", 64'(lat_last - lat_prev), 64'(FU * 20));
    wr(1, {20'd0, 2'd0, 2'd3, 2'd2, 2'd0, 4'b0001});
    f0 = frames;
    wait_frames(f0 + 3, "R8 slow run");
    chk(lat_last - lat_prev == SU * 4, "R8 slow code 3", 64'(lat_last - lat_prev), 64'(SU * 4));
    wr(0, 32'h0);
    idle(600);

    // R9: software ignored while periodic runs; periodic needs bit 30
    wr(1, {20'd0, 2'd0, 2'd0, 2'd2, 2'd0, 4'b0001});
    wr(0, 32'h4000_0000);
    f0 = frames;
    idle(100);
    wr(0, 32'hC000_0000);
    idle(1000);
    chk(frames == f0, "R9 strobe ignored", 64'(frames), 64'(f0));
    wr(0, 32'h0);
    f0 = frames;
    idle(3000);
    chk(frames == f0, "R9 no periodic without enable", 64'(frames), 64'(f0));
    wr(0, 32'h8000_0000);
    wait_frames(f0 + 1, "R9 software after disable");
    idle(400);
    chk(frames == f0 + 1, "R9 one software frame", 64'(frames), 64'(f0 + 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule